// File: doc/BRIEF.md
# Masked Interrupt Request Aggregator

This block collects interrupt requests from up to eight devices into a pending-request register and raises one shared, level-sensitive interrupt line toward the system interrupt controller. The line is high whenever at least one pending request is also enabled. Devices raise requests with a set vector and withdraw them with a clear vector. The host writes a mask in which a 1 means "blocked"; that mask is stored inverted as the enable vector.

The host clears one request at a time through the command port. The low four data bits select the bit index to clear. The host can read back the pending requests and the mask through the same small register window.

A second mask register, for a secondary controller, is stored and can be read back, but it never takes part in driving the line. There is no priority resolution, vector generation or cascading. The output is registered, and it changes only when the enabled-pending result changes.

Top module: `irq_aggregator`

## Requirements
- R1: A host write to address 2'b01 (primary mask) stores the inverted data as the enable vector. A read of address 2'b01 returns the mask as written, which reads 8'hFF after reset.
- R2: `irq_o` is high in the cycle after the AND of the request register and the enable vector becomes nonzero. It is low in the cycle after that AND becomes zero.
- R3: After a primary mask write, the line is re-evaluated against the new enable vector and updates on the next clock edge.
- R4: A host write to address 2'b00 (command) clears request bit `wdata[3:0]`. An index of 8 or more clears nothing. Data bits 7:4 are ignored.
- R5: Each bit set in `post_vec` sets that bit of the request register on the next edge.
- R6: Each bit set in `clr_vec` clears that request bit. The line drops if no enabled request remains.
- R7: When a set and a clear (by `clr_vec` or by command index) hit the same bit in one cycle, the set wins.
- R8: A read of address 2'b00 returns the request register. A read of address 2'b10 (secondary command) returns 0.
- R9: A write to address 2'b11 (secondary mask) stores the data unchanged, and a read of 2'b11 returns it. The value never affects `irq_o`.
- R10: Reset clears all requests, the enable vector and the secondary mask, and holds `irq_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| addr | input | 2 | Register address: 0 command, 1 mask, 2 secondary command, 3 secondary mask |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| post_vec | input | 8 | Device request set vector |
| clr_vec | input | 8 | Device request clear vector |
| irq_o | output | 1 | Registered shared interrupt line |

## Verification
The device set path can land in the same cycle as either clear path: the `clr_vec` strobe, or a host command write that selects the same bit index. The bench drives `post_vec` together with a matching `clr_vec`, and separately together with a command write naming that bit. The request register is read back in the following cycle and must still hold the bit. A reference model that applies the set after both clears predicts the line level, and a scoreboard compares that prediction against `irq_o` on every driven edge.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic [W-1:0] post_vec,
  input  logic [W-1:0] clr_vec,
  output logic         irq_o
);
  localparam int IW = 4;
  localparam logic [1:0] A_CMD  = 2'd0;
  localparam logic [1:0] A_MASK = 2'd1;
  localparam logic [1:0] A_SCMD = 2'd2;
  localparam logic [1:0] A_SMSK = 2'd3;

  logic [W-1:0] req_q, en_q, sec_q;
  logic [W-1:0] eoi_vec, req_d, en_d;
  logic [IW-1:0] eoi_idx;
  logic         irq_d;

  assign eoi_idx = wdata[IW-1:0];
  assign eoi_vec = (wr_en && addr == A_CMD && 32'(eoi_idx) < W)
                   ? (W'(1) << eoi_idx) : '0;
  assign req_d   = (req_q & ~clr_vec & ~eoi_vec) | post_vec;
  assign en_d    = (wr_en && addr == A_MASK) ? ~wdata : en_q;
  assign irq_d   = |(req_d & en_d);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= '0;
      en_q  <= '0;
      sec_q <= '0;
      irq_o <= 1'b0;
    end else begin
      req_q <= req_d;
      en_q  <= en_d;
      if (wr_en && addr == A_SMSK) sec_q <= wdata;
      if (irq_d != irq_o) irq_o <= irq_d;
    end
  end

  always_comb begin
    case (addr)
      A_CMD:   rdata = req_q;
      A_MASK:  rdata = ~en_q;
      A_SCMD:  rdata = '0;
      default: rdata = sec_q;
    endcase
  end
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [1:0]   addr,
  input logic [W-1:0] wdata,
  input logic [W-1:0] post_vec,
  input logic [W-1:0] clr_vec,
  input logic         irq_o,
  input logic [W-1:0] req_q,
  input logic [W-1:0] en_q
);
  logic [W-1:0] hot;
  assign hot = (wr_en && addr == 2'd0 && 32'(wdata[3:0]) < W) ? (W'(1) << wdata[3:0]) : '0;

  assert_irq_tracks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == |(req_q & en_q));

  assert_mask_invert_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd1) |=> en_q == ~$past(wdata));

  assert_post_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (post_vec != '0) |=> ($past(post_vec) & ~req_q) == '0);

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != '0) |=> (req_q & $past(clr_vec & ~post_vec)) == '0);

  assert_eoi_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hot != '0) |=> (req_q & $past(hot & ~post_vec)) == '0);

  assert_sec_isolated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd3 && post_vec == '0 && clr_vec == '0) |=> $stable(irq_o));
endmodule

bind irq_aggregator irq_aggregator_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .post_vec(post_vec), .clr_vec(clr_vec), .irq_o(irq_o),
  .req_q(req_q), .en_q(en_q)
);

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;
  logic       clk = 0, rst_n = 0, wr_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, post_vec = 0, clr_vec = 0, rdata;
  logic       irq_o;
  int checks = 0, fails = 0;
  bit done = 0;
  bit    exp_q[$];
  string tag_q[$];
  logic [7:0] m_req = 0, m_en = 0, m_sec = 0;

  irq_aggregator i_irq_aggregator (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .post_vec(post_vec), .clr_vec(clr_vec), .irq_o(irq_o));

  always #10 clk = ~clk;

  task automatic cyc(input bit wr, input logic [1:0] a, input logic [7:0] d,
                     input logic [7:0] p, input logic [7:0] c, input string tag);
    logic [7:0] eoi;
    @(negedge clk);
    wr_en = wr; addr = a; wdata = d; post_vec = p; clr_vec = c;
    eoi = (wr && a == 2'd0 && d[3:0] < 8) ? (8'd1 << d[3:0]) : 8'd0;
    m_req = (m_req & ~c & ~eoi) | p;
    if (wr && a == 2'd1) m_en = ~d;
    if (wr && a == 2'd3) m_sec = d;
    exp_q.push_back(|(m_req & m_en));
    tag_q.push_back(tag);
    @(posedge clk);
    #2;
    wr_en = 0; post_vec = 0; clr_vec = 0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr = a;
    #1;
    checks++;
    if (rdata !== exp) begin
      fails++;
      $display("FAIL %s rdata=%h expected=%h", tag, rdata, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (irq_o !== e) begin
          fails++;
          $display("FAIL %s irq_o=%b expected=%b", t, irq_o, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    checks++;
    if (irq_o !== 1'b0) begin
      fails++;
      $display("FAIL R10 irq_o=%b expected=0", irq_o);
    end
    rd(2'd0, 8'h00, "R10 req after reset");
    rd(2'd1, 8'hFF, "R10/R1 mask after reset");
    rd(2'd3, 8'h00, "R10 sec mask after reset");

    cyc(0, 0, 0, 8'h05, 0, "R5 post while all masked");
    rd(2'd0, 8'h05, "R5/R8 req read");
    cyc(1, 1, 8'hFE, 0, 0, "R1/R3 unmask bit0");
    rd(2'd1, 8'hFE, "R1 mask readback");
    cyc(1, 1, 8'hFF, 0, 0, "R3 mask all");
    cyc(1, 1, 8'hFB, 0, 0, "R3 unmask bit2");
    cyc(1, 0, 8'h02, 0, 0, "R4/R2 eoi bit2 drops line");
    rd(2'd0, 8'h01, "R4 eoi cleared bit2");
    cyc(1, 0, 8'h09, 0, 0, "R4 eoi index 9");
    rd(2'd0, 8'h01, "R4 index 9 clears nothing");
    cyc(1, 0, 8'hF0, 0, 0, "R4 eoi index 0 upper bits ignored");
    rd(2'd0, 8'h00, "R4 bit0 cleared");

    cyc(1, 1, 8'h7F, 0, 0, "R1 enable bit7");
    cyc(0, 0, 0, 8'h80, 0, "R2 post enabled bit7");
    cyc(0, 0, 0, 8'h01, 0, "R2 post masked bit0");
    cyc(0, 0, 0, 0, 8'h80, "R6 clr bit7 drops line");
    rd(2'd0, 8'h01, "R6 req after clr");

    cyc(0, 0, 0, 8'h80, 8'h81, "R7 set beats clr_vec");
    rd(2'd0, 8'h80, "R7 req after set+clr");
    cyc(1, 0, 8'h07, 8'h80, 0, "R7 set beats eoi");
    rd(2'd0, 8'h80, "R7 req after set+eoi");

    cyc(1, 3, 8'h5A, 0, 0, "R9 sec mask write, line held");
    rd(2'd3, 8'h5A, "R9 sec mask readback");
    rd(2'd2, 8'h00, "R8 secondary command reads 0");
    cyc(1, 1, 8'hFF, 0, 0, "R3 mask all drops line");
    cyc(1, 3, 8'h00, 0, 0, "R9 sec mask cannot raise line");
    cyc(0, 0, 0, 8'h3C, 0, "R2 post masked pattern");
    cyc(1, 1, 8'hEF, 0, 0, "R2 unmask bit4");
    cyc(0, 0, 0, 0, 8'h10, "R6 clr bit4");

    repeat (3) @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule